// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the type-1 configuration header of a PCI-to-PCI bridge: the command and status words, the primary, secondary and subordinate bus numbers, the secondary latency timer, the I/O, memory and prefetchable window base and limit registers with their upper extensions, and the bridge control word. Software reaches it through a dword-wide request port with per-byte enables. Reads answer one cycle later on a response channel.

Besides storage, the block produces the side effects that a bridge needs from its header. Any write whose enabled bytes land in a register that shapes the forwarding windows raises a one-cycle remap strobe. The remap strobe is raised in the cycle after the write, so the window logic downstream re-reads values that are already updated. A 0-to-1 change of the secondary-bus-reset control bit produces a one-cycle reset pulse. A separate disable input closes every window by pushing its base above its limit.

The request side is valid/ready. `req_ready` is tied high, so every request with `req_valid` high is accepted in that cycle. The response side has no ready: the requester must take `rsp_valid`/`rsp_rdata` in the cycle they appear. The window comparison and the physical bus interface are outside this block.

Top module: `bcfg_bridge_cfg`

## Requirements
- R1: `req_ready` is always 1. A read accepted in cycle N gives `rsp_valid`=1 with the addressed dword on `rsp_rdata` in cycle N+1. A write gives no response, and `rsp_valid` is 0 in every other cycle.
- R2: A write changes only bytes whose enable is set, and within them only writable bits. Command writable mask is 0x0547. Bridge control writable mask is 0x0FFF. Bus numbers and latency (dword 6) are fully writable. Window base and limit registers are writable only in their range bits. Both upper dwords (10, 11) and the I/O upper dword (12) are fully writable.
- R3: The read-only fields read fixed values. Dword 0 is {DEVICE_ID, VENDOR_ID}. Dword 2 is {0x060400, REV_ID}. Byte 0x0E is 0x01 with bit 7 = MULTI_FUNC. Primary status (bytes 6-7) and secondary status (bytes 0x1E-0x1F) read 0x00A0, which is 66 MHz capable (bit 5) and fast back-to-back capable (bit 7). The low nibble of I/O base/limit reads 0x1, the low nibble of memory base/limit reads 0x0, and the low nibble of prefetchable base/limit reads 0x1. Unimplemented dwords read 0, and writes to any of these fields have no effect.
- R4: A write raises `remap_strobe` exactly when an enabled byte falls in one of these byte ranges: 0x04-0x05, 0x1C-0x1D, 0x20-0x33 or 0x3E-0x3F. Writes that enable only other bytes, and writes with no byte enabled, leave it low.
- R5: `remap_strobe` is high for the single cycle after the write cycle, and a read issued in that cycle returns the new value.
- R6: `sec_bus_reset` pulses high for one cycle, in the cycle after a write that changes bridge-control bit 6 (byte 0x3E bit 6) from 0 to 1. Rewriting a 1 or clearing the bit produces no pulse.
- R7: After reset, the bus numbers, latency timer, command and bridge control are 0. All window range fields are 0, and the prefetchable and I/O upper dwords are 0.
- R8: A cycle with `disable_fwd` high sets every base range field to all ones and clears every limit range field. It also zeroes both prefetchable upper dwords and leaves the I/O upper dword unchanged. A write to those fields in the same cycle loses to the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Dword index into the 64-byte header |
| req_be | input | 4 | Byte enables for a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| disable_fwd | input | 1 | Close all forwarding windows |
| remap_strobe | output | 1 | Window registers changed |
| sec_bus_reset | output | 1 | Secondary bus reset pulse |

## Verification
The bench goes after partial-lane writes that straddle a window range and a neighbouring read-only field: status, secondary status, the interrupt bytes, and bus numbers. It also tries zero-enable writes. A decoder working at dword granularity would raise a spurious remap on these writes, and a missing mask would corrupt the status or type nibbles. It sets the bus-reset bit repeatedly and writes byte 0x3F alone. A level-based reset output would pulse on every rewrite, and a lane mix-up would fire from the wrong byte. It also fires the disable together with a write to the same window. Wrong precedence would leave an open window.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
  localparam int LANES   = 4;
  localparam int IDX_W   = 4;
  localparam int BADDR_W = IDX_W + 2;

  localparam logic [IDX_W-1:0] IDX_ID    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CMD   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 4'd2;
  localparam logic [IDX_W-1:0] IDX_HDR   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_BUS   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_IO    = 4'd7;
  localparam logic [IDX_W-1:0] IDX_MEM   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_PF    = 4'd9;
  localparam logic [IDX_W-1:0] IDX_PBU   = 4'd10;
  localparam logic [IDX_W-1:0] IDX_PLU   = 4'd11;
  localparam logic [IDX_W-1:0] IDX_IOU   = 4'd12;
  localparam logic [IDX_W-1:0] IDX_CTL   = 4'd15;

  localparam int          SBR_BIT      = 6;
  localparam logic [15:0] STATUS_CAPS  = 16'h00A0;
  localparam logic [15:0] CMD_WMASK    = 16'h0547;
  localparam logic [15:0] CTL_WMASK    = 16'h0FFF;
  localparam logic [23:0] CLASS_BRIDGE = 24'h060400;

  typedef struct packed {
    logic [15:0] cmd;
    logic [7:0]  pri_bus;
    logic [7:0]  sec_bus;
    logic [7:0]  sub_bus;
    logic [7:0]  sec_lat;
    logic [3:0]  io_base;
    logic [3:0]  io_lim;
    logic [11:0] mem_base;
    logic [11:0] mem_lim;
    logic [11:0] pf_base;
    logic [11:0] pf_lim;
    logic [31:0] pf_base_up;
    logic [31:0] pf_lim_up;
    logic [15:0] io_base_up;
    logic [15:0] io_lim_up;
    logic [15:0] ctl;
  } bcfg_state_t;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [31:0] mask,
                                             input logic [LANES-1:0] be);
    logic [31:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) begin
        r[8*i +: 8] = (old_v[8*i +: 8] & ~mask[8*i +: 8]) |
                      (new_v[8*i +: 8] & mask[8*i +: 8]);
      end
    end
    return r;
  endfunction

  function automatic logic window_byte(input logic [BADDR_W-1:0] b);
    return (b == 6'h04) || (b == 6'h05) || (b == 6'h1C) || (b == 6'h1D) ||
           ((b >= 6'h20) && (b <= 6'h33)) || (b == 6'h3E) || (b == 6'h3F);
  endfunction
endpackage

// File: rtl/bcfg_regs.sv
module bcfg_regs
  import bcfg_pkg::*;
#(
  parameter bit IO_32BIT   = 1'b1,
  parameter bit PREF_64BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  be,
  input  logic [31:0]       wdata,
  input  logic              dis_fwd,
  output bcfg_state_t       st
);
  localparam logic [31:0] PF_UP_MASK = PREF_64BIT ? 32'hFFFF_FFFF : 32'h0;
  localparam logic [31:0] IO_UP_MASK = IO_32BIT   ? 32'hFFFF_FFFF : 32'h0;

  bcfg_state_t nxt;
  logic [31:0] tmp;

  always_comb begin
    nxt = st;
    tmp = '0;
    if (wr_en) begin
      unique case (idx)
        IDX_CMD: begin
          tmp = lane_merge({16'h0, st.cmd}, wdata, {16'h0, CMD_WMASK}, be);
          nxt.cmd = tmp[15:0];
        end
        IDX_BUS: begin
          tmp = lane_merge({st.sec_lat, st.sub_bus, st.sec_bus, st.pri_bus},
                           wdata, 32'hFFFF_FFFF, be);
          {nxt.sec_lat, nxt.sub_bus, nxt.sec_bus, nxt.pri_bus} = tmp;
        end
        IDX_IO: begin
          tmp = lane_merge({16'h0, st.io_lim, 4'h0, st.io_base, 4'h0},
                           wdata, 32'h0000_F0F0, be);
          nxt.io_base = tmp[7:4];
          nxt.io_lim  = tmp[15:12];
        end
        IDX_MEM: begin
          tmp = lane_merge({st.mem_lim, 4'h0, st.mem_base, 4'h0},
                           wdata, 32'hFFF0_FFF0, be);
          nxt.mem_base = tmp[15:4];
          nxt.mem_lim  = tmp[31:20];
        end
        IDX_PF: begin
          tmp = lane_merge({st.pf_lim, 4'h0, st.pf_base, 4'h0},
                           wdata, 32'hFFF0_FFF0, be);
          nxt.pf_base = tmp[15:4];
          nxt.pf_lim  = tmp[31:20];
        end
        IDX_PBU: nxt.pf_base_up = lane_merge(st.pf_base_up, wdata, PF_UP_MASK, be);
        IDX_PLU: nxt.pf_lim_up  = lane_merge(st.pf_lim_up, wdata, PF_UP_MASK, be);
        IDX_IOU: begin
          tmp = lane_merge({st.io_lim_up, st.io_base_up}, wdata, IO_UP_MASK, be);
          {nxt.io_lim_up, nxt.io_base_up} = tmp;
        end
        IDX_CTL: begin
          tmp = lane_merge({st.ctl, 16'h0}, wdata, {CTL_WMASK, 16'h0}, be);
          nxt.ctl = tmp[31:16];
        end
        default: ;
      endcase
    end
    // Closing the windows overrides a same-cycle write to them.
    if (dis_fwd) begin
      nxt.io_base    = '1;
      nxt.io_lim     = '0;
      nxt.mem_base   = '1;
      nxt.mem_lim    = '0;
      nxt.pf_base    = '1;
      nxt.pf_lim     = '0;
      nxt.pf_base_up = '0;
      nxt.pf_lim_up  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= nxt;
  end
endmodule

// File: rtl/bcfg_side_fx.sv
module bcfg_side_fx
  import bcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] be,
  input  logic             sbr_bit,
  output logic             remap_strobe,
  output logic             sec_bus_reset
);
  logic [LANES-1:0] lane_hit;
  logic             remap_q;
  logic             sbr_prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = be[g] && window_byte({idx, 2'(g)});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q    <= 1'b0;
      sbr_prev_q <= 1'b0;
    end else begin
      remap_q    <= wr_en && (|lane_hit);
      sbr_prev_q <= sbr_bit;
    end
  end

  assign remap_strobe  = remap_q;
  assign sec_bus_reset = sbr_bit && !sbr_prev_q;
endmodule

// File: rtl/bcfg_read_mux.sv
module bcfg_read_mux
  import bcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0101,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter bit          IO_32BIT   = 1'b1,
  parameter bit          PREF_64BIT = 1'b1
) (
  input  bcfg_state_t      st,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      dword
);
  localparam logic [3:0] IO_TYPE = IO_32BIT   ? 4'h1 : 4'h0;
  localparam logic [3:0] PF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;
  localparam logic [7:0] HDR     = {MULTI_FUNC, 7'h01};

  always_comb begin
    unique case (idx)
      IDX_ID:    dword = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   dword = {STATUS_CAPS, st.cmd};
      IDX_CLASS: dword = {CLASS_BRIDGE, REV_ID};
      IDX_HDR:   dword = {8'h00, HDR, 16'h0000};
      IDX_BUS:   dword = {st.sec_lat, st.sub_bus, st.sec_bus, st.pri_bus};
      IDX_IO:    dword = {STATUS_CAPS, st.io_lim, IO_TYPE, st.io_base, IO_TYPE};
      IDX_MEM:   dword = {st.mem_lim, 4'h0, st.mem_base, 4'h0};
      IDX_PF:    dword = {st.pf_lim, PF_TYPE, st.pf_base, PF_TYPE};
      IDX_PBU:   dword = st.pf_base_up;
      IDX_PLU:   dword = st.pf_lim_up;
      IDX_IOU:   dword = {st.io_lim_up, st.io_base_up};
      IDX_CTL:   dword = {st.ctl, 16'h0000};
      default:   dword = 32'h0;
    endcase
  end
endmodule

// File: rtl/bcfg_bridge_cfg.sv
module bcfg_bridge_cfg
  import bcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h0101,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter bit          MULTI_FUNC = 1'b0,
  parameter bit          IO_32BIT   = 1'b1,
  parameter bit          PREF_64BIT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        disable_fwd,
  output logic        remap_strobe,
  output logic        sec_bus_reset
);
  bcfg_state_t st;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rd_word;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;

  bcfg_regs #(.IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(req_addr), .be(req_be),
    .wdata(req_wdata), .dis_fwd(disable_fwd), .st(st)
  );

  bcfg_read_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .MULTI_FUNC(MULTI_FUNC), .IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)
  ) u_rmux (
    .st(st), .idx(req_addr), .dword(rd_word)
  );

  bcfg_side_fx u_fx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(req_addr), .be(req_be),
    .sbr_bit(st.ctl[SBR_BIT]), .remap_strobe(remap_strobe),
    .sec_bus_reset(sec_bus_reset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/bcfg_checker.sv
module bcfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [3:0] req_be,
  input logic       rsp_valid,
  input logic       remap_strobe,
  input logic       sec_bus_reset
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  a_r1_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r5_remap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    remap_strobe |-> $past(req_valid && req_write));

  a_r4_no_lanes_no_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_be == 4'h0) |=> !remap_strobe);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bus_reset |=> !sec_bus_reset);

  a_r6_pulse_from_lane2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bus_reset |-> $past(req_valid && req_write && req_be[2]));
endmodule

bind bcfg_bridge_cfg bcfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_be(req_be), .rsp_valid(rsp_valid),
  .remap_strobe(remap_strobe), .sec_bus_reset(sec_bus_reset)
);

// File: tb/tb_bcfg_bridge_cfg.sv
module tb_bcfg_bridge_cfg;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, disable_fwd = 1'b0;
  logic [3:0]  req_addr = '0, req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, remap_strobe, sec_bus_reset;
  logic [31:0] rsp_rdata;

  bcfg_bridge_cfg dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .disable_fwd(disable_fwd), .remap_strobe(remap_strobe),
    .sec_bus_reset(sec_bus_reset)
  );

  // Behavioural byte-array model of the header.
  logic [7:0] cfg [64];
  logic [7:0] wm  [64];
  logic       exp_rv, exp_remap, exp_sbr;
  logic [31:0] exp_rd;
  string      exp_tag = "R1";
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic bit is_win(int b);
    return (b inside {4, 5, 28, 29, 62, 63}) || (b >= 32 && b < 52);
  endfunction

  task automatic model_init();
    for (int b = 0; b < 64; b++) begin cfg[b] = 8'h00; wm[b] = 8'h00; end
    cfg[0] = 8'hCD; cfg[1] = 8'hAB; cfg[2] = 8'h01; cfg[3] = 8'h01;
    cfg[6] = 8'hA0; cfg[8] = 8'h02; cfg[10] = 8'h04; cfg[11] = 8'h06;
    cfg[14] = 8'h01; cfg[28] = 8'h01; cfg[29] = 8'h01; cfg[30] = 8'hA0;
    cfg[36] = 8'h01; cfg[38] = 8'h01;
    wm[4] = 8'h47; wm[5] = 8'h05;
    for (int b = 24; b < 28; b++) wm[b] = 8'hFF;
    wm[28] = 8'hF0; wm[29] = 8'hF0;
    for (int b = 32; b < 40; b++) wm[b] = (b % 2 == 0) ? 8'hF0 : 8'hFF;
    for (int b = 40; b < 52; b++) wm[b] = 8'hFF;
    wm[62] = 8'hFF; wm[63] = 8'h0F;
    exp_rv = 0; exp_remap = 0; exp_sbr = 0; exp_rd = '0;
  endtask

  task automatic model_step(input logic v, input logic w, input logic [3:0] a,
                            input logic [3:0] be, input logic [31:0] d,
                            input logic dis, input string tag);
    logic old_sbr;
    int base;
    base = int'(a) * 4;
    old_sbr = cfg[62][6];
    exp_rv = v && !w;
    exp_remap = 0;
    if (v && !w) begin
      exp_rd = {cfg[base+3], cfg[base+2], cfg[base+1], cfg[base]};
      exp_tag = tag;
    end
    if (v && w) begin
      for (int i = 0; i < 4; i++) begin
        if (be[i]) begin
          cfg[base+i] = (cfg[base+i] & ~wm[base+i]) | (d[8*i +: 8] & wm[base+i]);
          if (is_win(base + i)) exp_remap = 1;
        end
      end
    end
    if (dis) begin
      cfg[28] = cfg[28] | 8'hF0; cfg[29] = cfg[29] & 8'h0F;
      cfg[32] = 8'hF0; cfg[33] = 8'hFF; cfg[34] = 8'h00; cfg[35] = 8'h00;
      cfg[36] = cfg[36] | 8'hF0; cfg[37] = 8'hFF;
      cfg[38] = cfg[38] & 8'h0F; cfg[39] = 8'h00;
      for (int b = 40; b < 48; b++) cfg[b] = 8'h00;
    end
    exp_sbr = !old_sbr && cfg[62][6];
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [3:0] a,
                     input logic [3:0] be, input logic [31:0] d,
                     input logic dis, input string tag);
    @(negedge clk);
    chk("R1", "req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, {31'b0, exp_rv});
    if (exp_rv) chk(exp_tag, "rsp_rdata", rsp_rdata, exp_rd);
    chk("R4", "remap_strobe", {31'b0, remap_strobe}, {31'b0, exp_remap});
    chk("R6", "sec_bus_reset", {31'b0, sec_bus_reset}, {31'b0, exp_sbr});
    req_valid = v; req_write = w; req_addr = a; req_be = be;
    req_wdata = d; disable_fwd = dis;
    model_step(v, w, a, be, d, dis, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(1, 1, a, be, d, 0, "R2");
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1, 0, a, 4'h0, 32'h0, 0, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 4'h0, 4'h0, 32'h0, 0, "R1");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; req_write = 0; disable_fwd = 0; req_be = '0;
    repeat (3) @(negedge clk);
    model_init();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_init();
    do_reset();
    // R7 / R3: reset image and fixed fields
    for (int a = 0; a < 16; a++) rd(4'(a), "R7");
    // R2 / R3: all-ones everywhere, then read back
    for (int a = 0; a < 16; a++) wr(4'(a), 4'hF, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd(4'(a), "R3");
    do_reset();
    for (int a = 0; a < 16; a++) rd(4'(a), "R7");
    // R4: lane-precise remap decode
    wr(4'd1, 4'b1100, 32'hFFFF_0000);  // status only
    wr(4'd1, 4'b0001, 32'h0000_0007);  // command
    wr(4'd7, 4'b1100, 32'h1234_0000);  // secondary status only
    wr(4'd7, 4'b0010, 32'h0000_5500);  // I/O limit
    wr(4'd15, 4'b0011, 32'h0000_A5A5); // interrupt bytes
    wr(4'd6, 4'hF, 32'h0020_0201);     // bus numbers
    wr(4'd8, 4'h0, 32'hFFFF_FFFF);     // no lanes
    wr(4'd12, 4'b1000, 32'h9900_0000); // I/O upper
    wr(4'd13, 4'hF, 32'hFFFF_FFFF);    // unimplemented
    idle();
    rd(4'd1, "R3"); rd(4'd7, "R3"); rd(4'd6, "R2"); rd(4'd12, "R2");
    // R5: read in the strobe cycle sees new value
    wr(4'd8, 4'hF, 32'h4560_1230);
    rd(4'd8, "R5");
    // R6: bus reset pulse on rising bit only
    wr(4'd15, 4'b0100, 32'h0040_0000);
    idle();
    wr(4'd15, 4'b0100, 32'h0048_0000);
    wr(4'd15, 4'b1000, 32'hFF40_0000);
    wr(4'd15, 4'b0100, 32'h0000_0000);
    wr(4'd15, 4'b0100, 32'h0040_0000);
    rd(4'd15, "R6");
    // R8: disable forwarding, alone and against a same-cycle write
    wr(4'd9, 4'hF, 32'h7770_1110);
    wr(4'd10, 4'hF, 32'hDEAD_BEEF);
    wr(4'd12, 4'hF, 32'h1111_2222);
    cyc(0, 0, 4'd0, 4'h0, 32'h0, 1, "R8");
    for (int a = 7; a < 13; a++) rd(4'(a), "R8");
    cyc(1, 1, 4'd8, 4'hF, 32'h0000_FFF0, 1, "R8");
    rd(4'd8, "R8"); rd(4'd11, "R8");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], r[2], r[7:4], r[11:8], $urandom, (r[15:12] == 4'h0), "R2");
    end
    for (int a = 0; a < 16; a++) rd(4'(a), "R2");
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule